// File: doc/BRIEF.md
# S/PDIF Biphase Transmitter Front End

This block turns a three-wire serial stereo audio input into one biphase-mark line that carries S/PDIF. The wires are the bit clock, the word select and the data. The serial wires and an enable at twice the line bit rate are synchronous to the system clock. On each rising bit clock the deserializer picks the audio word out of each half-frame. The format selector sets where the word sits in the half-frame, and the width selector sets how many bits it has. When a right word completes, the left and right words are handed to the framer as one stereo pair.

The framer builds two 32-slot subframes for each frame. Each subframe holds a preamble, 24 audio slots, and the validity, user, channel-status and parity slots. The encoder emits one half-cell on every enable pulse. The input has no back-pressure. The deserializer presents a pair with a valid flag, and the framer acts as its ready side: it takes the pair on the enable pulse that starts a left subframe. A newer pair overwrites one that has not been taken. If no pair is waiting, the previous pair is sent again and flagged invalid.

Top module: `spdif_tx_front`

## Requirements
- R1: `fmt_sel` sets the position of the word in each half-frame of 32 bit clocks, counting bit clock rises from the first rise after `ser_lrclk` changes, which is index 0. Code 0 (and the reserved code 3) puts the MSB at index 0. Code 1 puts it at index 1. Code 2 ends the word with its LSB at index 31. `ser_lrclk` low marks the left channel.
- R2: `width_sel` codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. Data bits outside the word's positions do not change the output.
- R3: Slots 4 to 27 carry the word left-aligned in 24 bits and sent LSB first. A shorter word has zeros in its lowest slots.
- R4: Slots 0 to 3 hold the preamble. Slot 28 is validity, slot 29 is the user bit and slot 30 is the channel-status bit. The user and channel-status bits are sampled from `usr_bit` and `cs_bit` at the start of each frame.
- R5: In slots 4 to 31 the line inverts at the start of every slot. It inverts again mid-slot only when the slot bit is 1.
- R6: The preamble half-cells, relative to the line level before them, are 11101000 for a block start, 11100010 for other left subframes and 11100100 for right subframes. A block is 192 frames, and the first frame after reset starts a block.
- R7: The output is registered. It moves by one half-cell on each clock edge where `cell_en` is high and is otherwise held.
- R8: On the pulse that starts a left subframe, a waiting pair is taken and its validity slots are 0. With no pair waiting, the last pair is repeated with validity 1. A pair that arrives before the previous one is taken replaces it.
- R9: Slot 31 gives even parity over slots 4 to 31, so each subframe ends at the level it started from.
- R10: During reset the output is low, the framer points at the first half-cell of a block, and the held samples are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_en | input | 1 | Half-cell enable at twice the line bit rate |
| ser_bclk | input | 1 | Serial bit clock, sampled in `clk` |
| ser_lrclk | input | 1 | Word select, low = left |
| ser_data | input | 1 | Serial audio data |
| fmt_sel | input | 2 | 0 left-justified, 1 I2S, 2 right-justified, 3 as 0 |
| width_sel | input | 2 | 0:16, 1:18, 2:20, 3:24 bits |
| usr_bit | input | 1 | User bit for the next frame |
| cs_bit | input | 1 | Channel-status bit for the next frame |
| spdif_out | output | 1 | Biphase-mark line |

## Verification
A half-cell appears on `spdif_out` at the same clock edge where `cell_en` is high, so it can be read half a clock later. A word completes at the bit clock rise edge that carries its last bit. It reaches the line in half-cells 8 to 55 of the first left subframe whose start pulse comes after that edge, and its validity follows in half-cells 56 to 57. The bench steps a behavioural model at every rising edge using the same input values and compares the line at every falling edge. Each half-cell's result is therefore checked in the cycle where it becomes due, and a missing hold between pulses is caught in the cycle it happens.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int unsigned AUD_BITS   = 24;
  localparam int unsigned SUB_CELLS  = 64;

  typedef enum logic [1:0] {FMT_LJ = 2'd0, FMT_I2S = 2'd1, FMT_RJ = 2'd2, FMT_RSV = 2'd3} sfmt_e;
  typedef enum logic [1:0] {PRE_BLK = 2'd0, PRE_LEFT = 2'd1, PRE_RIGHT = 2'd2} pre_e;

  function automatic int unsigned width_of(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // bit 7 is the first half-cell, relative to the level before the preamble
  function automatic logic [7:0] pre_pattern(input pre_e kind);
    case (kind)
      PRE_BLK:  return 8'b1110_1000;
      PRE_LEFT: return 8'b1110_0010;
      default:  return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/spdif_deser.sv
module spdif_deser
  import spdif_tx_pkg::*;
#(
  parameter int unsigned HALF_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_bclk,
  input  logic                ser_lrclk,
  input  logic                ser_data,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wsel,
  input  logic                take,
  output logic                pair_valid,
  output logic                pair_done,
  output logic [AUD_BITS-1:0] pair_left,
  output logic [AUD_BITS-1:0] pair_right
);
  localparam int unsigned CW = $clog2(HALF_BITS) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic                bclk_q, ws_q;
  logic [CW-1:0]       cnt_q;
  logic [AUD_BITS-1:0] word_q, lhold_q;

  logic                rise, new_half, in_word, last_bit;
  logic [CW-1:0]       idx, wd, start, k;
  logic [CW:0]         stop;
  logic [AUD_BITS-1:0] wnext;

  always_comb begin
    rise     = ser_bclk & ~bclk_q;
    new_half = ser_lrclk ^ ws_q;
    if (new_half)           idx = '0;
    else if (cnt_q == CMAX) idx = CMAX;
    else                    idx = cnt_q + 1'b1;
    wd = CW'(width_of(wsel));
    case (sfmt_e'(fmt))
      FMT_I2S: start = CW'(1);
      FMT_RJ:  start = CW'(HALF_BITS) - wd;
      default: start = '0;
    endcase
    stop     = {1'b0, start} + {1'b0, wd};
    in_word  = (idx >= start) && ({1'b0, idx} < stop);
    k        = idx - start;
    last_bit = in_word && (k == wd - 1'b1);
    wnext    = (k == '0) ? '0 : word_q;
    wnext    = wnext | (AUD_BITS'(ser_data) << (int'(AUD_BITS) - 1 - int'(k)));
    pair_done = rise & last_bit & ser_lrclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      ws_q       <= 1'b0;
      cnt_q      <= CMAX;
      word_q     <= '0;
      lhold_q    <= '0;
      pair_left  <= '0;
      pair_right <= '0;
      pair_valid <= 1'b0;
    end else begin
      bclk_q <= ser_bclk;
      if (rise) begin
        ws_q  <= ser_lrclk;
        cnt_q <= idx;
        if (in_word) word_q <= wnext;
        if (last_bit && !ser_lrclk) lhold_q <= wnext;
      end
      if (pair_done) begin
        pair_left  <= lhold_q;
        pair_right <= wnext;
        pair_valid <= 1'b1;
      end else if (take) begin
        pair_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spdif_framer.sv
module spdif_framer
  import spdif_tx_pkg::*;
#(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned FW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cell_en,
  input  logic                pair_valid,
  input  logic [AUD_BITS-1:0] pair_left,
  input  logic [AUD_BITS-1:0] pair_right,
  input  logic                usr_bit,
  input  logic                cs_bit,
  output logic                take,
  output logic [5:0]          cell_idx,
  output logic                sub_sel,
  output logic [FW-1:0]       frm_idx,
  output logic                is_pre,
  output logic                first_cell,
  output logic                pre_bit,
  output logic                data_bit,
  output logic                v_flag
);
  logic [5:0]          cell_q;
  logic                sub_q;
  logic [FW-1:0]       frm_q;
  logic [AUD_BITS-1:0] bufl_q, bufr_q, aud;
  logic                v_q, u_q, c_q, frame_start, par;
  logic [4:0]          slot;
  logic [27:0]         payload;
  logic [7:0]          pat;
  pre_e                kind;

  always_comb begin
    frame_start = (cell_q == 6'd0) && !sub_q;
    take        = cell_en & frame_start & pair_valid;
    aud         = sub_q ? bufr_q : bufl_q;
    par         = ^{c_q, u_q, v_q, aud};
    payload     = {par, c_q, u_q, v_q, aud};
    slot        = cell_q[5:1];
    is_pre      = (cell_q[5:3] == 3'd0);
    first_cell  = (cell_q == 6'd0);
    if (sub_q)              kind = PRE_RIGHT;
    else if (frm_q == '0)   kind = PRE_BLK;
    else                    kind = PRE_LEFT;
    pat      = pre_pattern(kind);
    pre_bit  = pat[3'd7 - cell_q[2:0]];
    data_bit = is_pre ? 1'b0 : payload[slot - 5'd4];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_q <= '0;
      sub_q  <= 1'b0;
      frm_q  <= '0;
      bufl_q <= '0;
      bufr_q <= '0;
      v_q    <= 1'b1;
      u_q    <= 1'b0;
      c_q    <= 1'b0;
    end else if (cell_en) begin
      if (frame_start) begin
        if (pair_valid) begin
          bufl_q <= pair_left;
          bufr_q <= pair_right;
        end
        v_q <= ~pair_valid;
        u_q <= usr_bit;
        c_q <= cs_bit;
      end
      cell_q <= cell_q + 6'd1;
      if (cell_q == 6'(SUB_CELLS - 1)) begin
        sub_q <= ~sub_q;
        if (sub_q) frm_q <= (frm_q == FW'(FRAMES - 1)) ? '0 : frm_q + 1'b1;
      end
    end
  end

  assign cell_idx = cell_q;
  assign sub_sel  = sub_q;
  assign frm_idx  = frm_q;
  assign v_flag   = v_q;
endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_en,
  input  logic is_pre,
  input  logic first_cell,
  input  logic half,
  input  logic pre_bit,
  input  logic data_bit,
  output logic line_out,
  output logic base_out
);
  logic line_q, base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      base_q <= 1'b0;
    end else if (cell_en) begin
      if (is_pre) begin
        if (first_cell) base_q <= line_q;
        line_q <= (first_cell ? line_q : base_q) ^ pre_bit;
      end else if (!half) begin
        line_q <= ~line_q;
      end else begin
        line_q <= line_q ^ data_bit;
      end
    end
  end

  assign line_out = line_q;
  assign base_out = base_q;
endmodule

// File: rtl/spdif_tx_front.sv
module spdif_tx_front
  import spdif_tx_pkg::*;
#(
  parameter int unsigned HALF_BITS        = 32,
  parameter int unsigned FRAMES_PER_BLOCK = 192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_en,
  input  logic       ser_bclk,
  input  logic       ser_lrclk,
  input  logic       ser_data,
  input  logic [1:0] fmt_sel,
  input  logic [1:0] width_sel,
  input  logic       usr_bit,
  input  logic       cs_bit,
  output logic       spdif_out
);
  localparam int unsigned FW = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;

  logic                pair_valid, pair_done, take;
  logic [AUD_BITS-1:0] pair_left, pair_right;
  logic [5:0]          cell_idx;
  logic                sub_sel, is_pre, first_cell, pre_bit, data_bit, v_flag, enc_base;
  logic [FW-1:0]       frm_idx;

  spdif_deser #(.HALF_BITS(HALF_BITS)) u_deser (
    .clk(clk), .rst_n(rst_n), .ser_bclk(ser_bclk), .ser_lrclk(ser_lrclk),
    .ser_data(ser_data), .fmt(fmt_sel), .wsel(width_sel), .take(take),
    .pair_valid(pair_valid), .pair_done(pair_done),
    .pair_left(pair_left), .pair_right(pair_right)
  );

  spdif_framer #(.FRAMES(FRAMES_PER_BLOCK)) u_frm (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .pair_valid(pair_valid),
    .pair_left(pair_left), .pair_right(pair_right), .usr_bit(usr_bit),
    .cs_bit(cs_bit), .take(take), .cell_idx(cell_idx), .sub_sel(sub_sel),
    .frm_idx(frm_idx), .is_pre(is_pre), .first_cell(first_cell),
    .pre_bit(pre_bit), .data_bit(data_bit), .v_flag(v_flag)
  );

  spdif_bmc_enc u_enc (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .is_pre(is_pre),
    .first_cell(first_cell), .half(cell_idx[0]), .pre_bit(pre_bit),
    .data_bit(data_bit), .line_out(spdif_out), .base_out(enc_base)
  );
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned FW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cell_en,
  input logic          spdif_out,
  input logic          is_pre,
  input logic [5:0]    cell_idx,
  input logic          sub_sel,
  input logic          data_bit,
  input logic          pair_valid,
  input logic          pair_done,
  input logic          take,
  input logic          v_flag,
  input logic          enc_base,
  input logic [FW-1:0] frm_idx
);
  // R7: line held between enable pulses
  p_hold_between_cells_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_en |=> $stable(spdif_out));

  // R5: slot boundary always inverts the line
  p_slot_edge_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && !is_pre && !cell_idx[0]) |=> (spdif_out != $past(spdif_out)));

  // R5: zero bit has no mid-slot transition
  p_zero_no_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && !is_pre && cell_idx[0] && !data_bit) |=> $stable(spdif_out));

  // R9: even parity returns the line to its pre-preamble level
  p_subframe_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && cell_idx == 6'd63) |=> (spdif_out == enc_base));

  // R8: a taken pair is consumed unless a new one lands at once
  p_take_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pair_done) |=> !pair_valid);

  // R8: frame start without a pair marks the frame invalid
  p_underrun_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && cell_idx == 6'd0 && !sub_sel && !pair_valid) |=> v_flag);

  // R6: frame counter stays inside the block
  p_block_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en |-> (int'(frm_idx) < int'(FRAMES)));
endmodule

bind spdif_tx_front spdif_tx_chk #(.FRAMES(FRAMES_PER_BLOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .spdif_out(spdif_out),
  .is_pre(is_pre), .cell_idx(cell_idx), .sub_sel(sub_sel), .data_bit(data_bit),
  .pair_valid(pair_valid), .pair_done(pair_done), .take(take),
  .v_flag(v_flag), .enc_base(enc_base), .frm_idx(frm_idx)
);

// File: tb/sim_spdif_tx_front.sv
`timescale 1ns/1ps
module sim_spdif_tx_front;
  logic clk = 1'b0, rst_n = 1'b0, cell_en = 1'b0;
  logic ser_bclk = 1'b0, ser_lrclk = 1'b0, ser_data = 1'b0;
  logic [1:0] fmt_sel = 2'd0, width_sel = 2'd0;
  logic usr_bit = 1'b0, cs_bit = 1'b0;
  logic spdif_out;

  always #10 clk = ~clk;

  spdif_tx_front u0 (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .ser_bclk(ser_bclk),
    .ser_lrclk(ser_lrclk), .ser_data(ser_data), .fmt_sel(fmt_sel),
    .width_sel(width_sel), .usr_bit(usr_bit), .cs_bit(cs_bit), .spdif_out(spdif_out)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  task automatic fail(input string tag, input int act, input int exp);
    miscompares++;
    $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, act, exp);
  endtask

  // ---------------- behavioural reference ----------------
  int m_cnt, m_cell, m_frm, m_sub;
  bit m_bq, m_ws, m_pv, m_v, m_u, m_c, m_line, m_base, m_en;
  logic [23:0] m_word, m_lh, m_pl, m_pr, m_bl, m_br;
  string m_tag = "R10";

  function automatic int wbits(input logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 18 : (c == 2) ? 20 : 24;
  endfunction
  function automatic int first_idx(input logic [1:0] f, input int w);
    return (f == 1) ? 1 : (f == 2) ? 32 - w : 0;
  endfunction
  function automatic bit pre_cell(input int kind, input int i);
    logic [7:0] p;
    p = (kind == 0) ? 8'b11101000 : (kind == 1) ? 8'b11100010 : 8'b11100100;
    return p[7 - i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 63; m_cell = 0; m_frm = 0; m_sub = 0;
      m_bq = 0; m_ws = 0; m_pv = 0; m_v = 1; m_u = 0; m_c = 0;
      m_line = 0; m_base = 0; m_en = 0;
      m_word = 0; m_lh = 0; m_pl = 0; m_pr = 0; m_bl = 0; m_br = 0;
      m_tag = "R10";
    end else begin
      bit took, setp, b;
      int w, st, idx, k, slot, kind;
      logic [23:0] aud;
      took = 0; setp = 0; b = 0;
      m_en = cell_en;
      if (cell_en) begin
        if (m_cell == 0 && m_sub == 0) begin
          if (m_pv) begin m_bl = m_pl; m_br = m_pr; took = 1; end
          m_v = !m_pv; m_u = usr_bit; m_c = cs_bit;
        end
        slot = m_cell / 2;
        if (m_cell < 8) begin
          kind = (m_sub == 1) ? 2 : (m_frm == 0) ? 0 : 1;
          if (m_cell == 0) m_base = m_line;
          m_line = m_base ^ pre_cell(kind, m_cell);
          m_tag = "R6 preamble";
        end else begin
          aud = m_sub ? m_br : m_bl;
          if (slot < 28)       begin b = aud[slot - 4]; m_tag = "R1 R2 R3 R5 audio"; end
          else if (slot == 28) begin b = m_v;           m_tag = "R8 validity"; end
          else if (slot == 29) begin b = m_u;           m_tag = "R4 user"; end
          else if (slot == 30) begin b = m_c;           m_tag = "R4 status"; end
          else begin b = (^aud) ^ m_v ^ m_u ^ m_c;      m_tag = "R9 parity"; end
          if (m_cell % 2 == 0) m_line = !m_line;
          else m_line = m_line ^ b;
        end
        m_cell++;
        if (m_cell == 64) begin
          m_cell = 0;
          if (m_sub == 1) m_frm = (m_frm == 191) ? 0 : m_frm + 1;
          m_sub = 1 - m_sub;
        end
      end
      if (ser_bclk && !m_bq) begin
        w = wbits(width_sel);
        st = first_idx(fmt_sel, w);
        idx = (ser_lrclk != m_ws) ? 0 : (m_cnt >= 63 ? 63 : m_cnt + 1);
        m_ws = ser_lrclk; m_cnt = idx;
        if (idx >= st && idx < st + w) begin
          k = idx - st;
          if (k == 0) m_word = 0;
          m_word[23 - k] = ser_data;
          if (k == w - 1) begin
            if (!ser_lrclk) m_lh = m_word;
            else begin m_pl = m_lh; m_pr = m_word; m_pv = 1; setp = 1; end
          end
        end
      end
      if (took && !setp) m_pv = 0;
      m_bq = ser_bclk;
    end
  end

  // ---------------- comparison, away from the active edge ----------------
  bit last_out = 0;
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (!rst_n) begin
        if (spdif_out !== 1'b0) fail("R10 reset level", spdif_out, 0);
      end else begin
        if (!m_en && spdif_out !== last_out) fail("R7 hold", spdif_out, last_out);
        if (spdif_out !== m_line) fail(m_tag, spdif_out, m_line);
      end
      last_out = spdif_out;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    forever begin
      @(negedge clk);
      cell_en = ~cell_en;
    end
  end

  function automatic bit ser_bit(input logic [1:0] f, input int w, input logic [23:0] s, input int i);
    int st;
    st = first_idx(f, w);
    if (i >= st && i < st + w) return s[w - 1 - (i - st)];
    return 1'($urandom);
  endfunction

  task automatic send_half(input bit ch, input logic [23:0] s, input int ph);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ser_bclk = 0; ser_lrclk = ch; ser_data = ser_bit(fmt_sel, wbits(width_sel), s, i);
      repeat (ph - 1) @(negedge clk);
      @(negedge clk);
      ser_bclk = 1;
      repeat (ph - 1) @(negedge clk);
    end
  endtask

  task automatic send_frames(input int n, input int ph);
    for (int f = 0; f < n; f++) begin
      logic [23:0] l, r;
      l = 24'($urandom); r = 24'($urandom);
      usr_bit = 1'($urandom); cs_bit = 1'($urandom);
      send_half(1'b0, l, ph);
      send_half(1'b1, r, ph);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 4; w++) begin
        if (!(f == 3 && w > 0)) begin
          fmt_sel = 2'(f); width_sel = 2'(w);
          send_frames((f == 3) ? 8 : 20, 2);
        end
      end
    end
    repeat (2000) @(negedge clk);
    fmt_sel = 2'd1; width_sel = 2'd3;
    send_frames(12, 1);
    send_frames(6, 2);
    repeat (300) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fail("watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule